// File: doc/BRIEF.md
# UART Line Status Tracker

This block keeps the line status of a serial port receiver and transmitter and presents it as one 8-bit read-only status word on a simple register read port. Received characters enter a small FIFO together with three error tags (parity, framing, break). The block keeps a running count of tagged entries so that a FIFO-wide error summary can be reported. A separate detector watches the raw serial input at the 16x sample rate and flags a break once the line has stayed low for longer than one complete character frame. The frame length follows the configured data length, parity and stop bits.

On the transmit side the block follows the holding FIFO and the shift register. It reports holding-empty and transmitter-empty, and raises a transmit-empty interrupt request when that source is enabled. Overrun, parity, framing and break are sticky bits that clear when the CPU reads the status word. A set event that lands in the same cycle as the read wins, so that event is not lost. The summary bit is stickier still: it clears on a read only when no tagged character remains queued.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status word reads 0x60 (holding empty and transmitter empty, all other bits 0), and the interrupt output is 0.
- R2: Status bit 0 is 1 while the receive FIFO holds any character. Characters pop in the order they were pushed, and the head character appears on `rx_dout`.
- R3: A push into a full FIFO with no pop in the same cycle discards the character and sets status bit 1. A later status read clears bit 1.
- R4: An accepted push tagged with a parity error sets bit 2. One tagged with a framing error (stop bit sampled as 0) sets bit 3. Both bits clear on a status read, which is `rd_en` high with `rd_addr` equal to 0x14. A read at any other address returns 0 and clears nothing.
- R5: Status bit 7 is 1 whenever at least one queued character carries a parity, framing or break tag. A status read does not clear it while such a character remains.
- R6: After the last tagged character leaves the FIFO, bit 7 stays 1 until the next status read and is 0 after that read.
- R7: Status bit 4 sets when `serial_in` is sampled low on more than W consecutive sample ticks. W = 16 x (1 start + data bits + parity bit if enabled + stop bits). The data length code 0..3 selects 5..8 data bits. Exactly W low samples do not set it.
- R8: When a set event for a sticky bit (bits 1 to 4) occurs in the same cycle as a status read, the bit is 1 after the read.
- R9: Bit 5 sets when a load moves the last word (level 1) from the transmit FIFO into the shift register. A write to the holding register clears it. A load at a level above 1 leaves it unchanged.
- R10: Bit 6 is 1 only when bit 5 is 1, the transmit FIFO level is 0 and the shift register reports empty.
- R11: `tx_irq` is 1 exactly when bit 5 is 1 and `thre_irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register offset; status word at 0x14 |
| rd_data | output | 8 | Status word during a status read, else 0 |
| rx_push | input | 1 | Push received character |
| rx_char | input | 8 | Received character |
| rx_pe | input | 1 | Parity error tag |
| rx_fe | input | 1 | Framing error tag |
| rx_bi | input | 1 | Break tag |
| rx_pop | input | 1 | Pop head character |
| rx_dout | output | 8 | Head character |
| serial_in | input | 1 | Raw serial input |
| sample_tick | input | 1 | 16x baud sample enable |
| cfg_len | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_parity | input | 1 | Parity bit enabled |
| cfg_two_stop | input | 1 | Two stop bits |
| thr_write | input | 1 | CPU write to holding register |
| tx_load | input | 1 | Word moved from TX FIFO to shift register |
| tx_level | input | 5 | TX FIFO level before this cycle's load |
| tx_shift_empty | input | 1 | Shift register empty |
| thre_irq_en | input | 1 | Transmit-empty interrupt enable |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The bench builds the block with a receive FIFO depth of 4. With that depth, a full FIFO and the discarded push behind it take only a few cycles, while pointer wrap and error counting through the queue are still covered. The sample tick is held high every cycle, so a break threshold of 112 or 192 samples is reached in a few hundred clocks. This lets both the exact-threshold case and the one-sample-beyond case be checked for the shortest and the longest frame. Holding the line low past the threshold until the bench's own status read lands on the setting edge makes the set-wins-over-read case occur naturally.

// File: rtl/uls_pkg.sv
package uls_pkg;

  // bit positions in the status word
  localparam int unsigned ST_RDY  = 0;
  localparam int unsigned ST_OVR  = 1;
  localparam int unsigned ST_PAR  = 2;
  localparam int unsigned ST_FRM  = 3;
  localparam int unsigned ST_BRK  = 4;
  localparam int unsigned ST_THRE = 5;
  localparam int unsigned ST_TEMT = 6;
  localparam int unsigned ST_ESUM = 7;

  localparam int unsigned MAX_FRAME_BITS = 12;

  typedef struct packed {
    logic       bi;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  // bits in one frame: start + data + optional parity + stop
  function automatic int unsigned frame_bits(input logic [1:0] len_code,
                                             input logic parity,
                                             input logic two_stop);
    int unsigned n;
    n = 1 + 5 + int'(len_code);
    if (parity) n = n + 1;
    n = n + (two_stop ? 2 : 1);
    return n;
  endfunction

  function automatic logic entry_tagged(input rx_entry_t e);
    return e.pe | e.fe | e.bi;
  endfunction

endpackage

// File: rtl/uls_rx_fifo.sv
module uls_rx_fifo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  uls_pkg::rx_entry_t din,
  output uls_pkg::rx_entry_t head,
  output logic              empty,
  output logic              full,
  output logic              push_ok,
  output logic              pop_ok
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  uls_pkg::rx_entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uls_err_track.sv
module uls_err_track #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_tagged,
  input  logic          drop_tagged,
  input  logic          status_rd,
  output logic [CW-1:0] err_count,
  output logic          err_sum
);
  logic [CW-1:0] count_nx;

  always_comb begin
    count_nx = err_count;
    if (add_tagged && !drop_tagged)      count_nx = err_count + CW'(1);
    else if (drop_tagged && !add_tagged) count_nx = err_count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count <= '0;
      err_sum   <= 1'b0;
    end else begin
      err_count <= count_nx;
      err_sum   <= (count_nx != '0) | (err_sum & ~status_rd);
    end
  end
endmodule

// File: rtl/uls_break_det.sv
module uls_break_det #(
  parameter int unsigned OSR = 16,
  localparam int unsigned CW = $clog2(OSR * uls_pkg::MAX_FRAME_BITS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          serial_in,
  input  logic [CW-1:0] threshold,
  output logic          brk_evt
);
  logic [CW-1:0] low_cnt;

  // fires once, on the first low sample beyond the threshold
  assign brk_evt = sample_tick & ~serial_in & (low_cnt == threshold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (sample_tick) begin
      if (serial_in)                low_cnt <= '0;
      else if (low_cnt <= threshold) low_cnt <= low_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/uls_tx_track.sv
module uls_tx_track #(
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_write,
  input  logic          tx_load,
  input  logic [LW-1:0] tx_level,
  input  logic          tx_shift_empty,
  input  logic          irq_en,
  output logic          thre,
  output logic          temt,
  output logic          irq
);
  logic last_load;

  assign last_load = tx_load & (tx_level == LW'(1));
  assign temt      = thre & tx_shift_empty & (tx_level == '0);
  assign irq       = thre & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         thre <= 1'b1;
    else if (thr_write) thre <= 1'b0;
    else if (last_load) thre <= 1'b1;
  end
endmodule

// File: rtl/uls_sticky.sv
module uls_sticky #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set[i] | (q[i] & ~clr);
    end
  end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned OSR        = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STATUS_OFS = 'h14,
  parameter int unsigned LW         = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              rx_push,
  input  logic [7:0]        rx_char,
  input  logic              rx_pe,
  input  logic              rx_fe,
  input  logic              rx_bi,
  input  logic              rx_pop,
  output logic [7:0]        rx_dout,
  input  logic              serial_in,
  input  logic              sample_tick,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_parity,
  input  logic              cfg_two_stop,
  input  logic              thr_write,
  input  logic              tx_load,
  input  logic [LW-1:0]     tx_level,
  input  logic              tx_shift_empty,
  input  logic              thre_irq_en,
  output logic              tx_irq
);
  import uls_pkg::*;

  localparam int unsigned ECW = $clog2(DEPTH + 1);
  localparam int unsigned BCW = $clog2(OSR * MAX_FRAME_BITS + 2);
  localparam int unsigned NSTICKY = 4;

  // named internal events
  logic            status_rd;
  logic            rx_accept, rx_pop_ok, rx_empty, rx_full;
  logic            overrun_evt, pe_set, fe_set, brk_evt;
  logic [ECW-1:0]  err_count;
  logic            err_sum, thre, temt;
  logic [BCW-1:0]  brk_threshold;
  logic [NSTICKY-1:0] sticky_set, sticky_q;
  logic [7:0]      status_word;
  rx_entry_t       rx_in, rx_head;

  assign status_rd = rd_en & (rd_addr == ADDR_W'(STATUS_OFS));

  assign rx_in = '{bi: rx_bi, fe: rx_fe, pe: rx_pe, data: rx_char};

  uls_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (rx_push),
    .pop     (rx_pop),
    .din     (rx_in),
    .head    (rx_head),
    .empty   (rx_empty),
    .full    (rx_full),
    .push_ok (rx_accept),
    .pop_ok  (rx_pop_ok)
  );

  assign rx_dout     = rx_head.data;
  assign overrun_evt = rx_push & ~rx_accept;
  assign pe_set      = rx_accept & rx_pe;
  assign fe_set      = rx_accept & rx_fe;

  uls_err_track #(.DEPTH(DEPTH)) u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .add_tagged  (rx_accept & entry_tagged(rx_in)),
    .drop_tagged (rx_pop_ok & entry_tagged(rx_head)),
    .status_rd   (status_rd),
    .err_count   (err_count),
    .err_sum     (err_sum)
  );

  assign brk_threshold = BCW'(OSR * frame_bits(cfg_len, cfg_parity, cfg_two_stop));

  uls_break_det #(.OSR(OSR)) u_brk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .serial_in   (serial_in),
    .threshold   (brk_threshold),
    .brk_evt     (brk_evt)
  );

  uls_tx_track #(.LW(LW)) u_tx (
    .clk            (clk),
    .rst_n          (rst_n),
    .thr_write      (thr_write),
    .tx_load        (tx_load),
    .tx_level       (tx_level),
    .tx_shift_empty (tx_shift_empty),
    .irq_en         (thre_irq_en),
    .thre           (thre),
    .temt           (temt),
    .irq            (tx_irq)
  );

  // sticky order: overrun, parity, framing, break (status bits 1..4)
  assign sticky_set = {brk_evt, fe_set, pe_set, overrun_evt};

  uls_sticky #(.N(NSTICKY)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sticky_set),
    .clr   (status_rd),
    .q     (sticky_q)
  );

  always_comb begin
    status_word          = '0;
    status_word[ST_RDY]  = ~rx_empty;
    status_word[ST_OVR]  = sticky_q[0];
    status_word[ST_PAR]  = sticky_q[1];
    status_word[ST_FRM]  = sticky_q[2];
    status_word[ST_BRK]  = sticky_q[3];
    status_word[ST_THRE] = thre;
    status_word[ST_TEMT] = temt;
    status_word[ST_ESUM] = err_sum;
  end

  assign rd_data = status_rd ? status_word : 8'h00;

endmodule

// File: rtl/uls_checker.sv
module uls_checker #(
  parameter int unsigned ECW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     status_word,
  input logic           status_rd,
  input logic [ECW-1:0] err_count,
  input logic           overrun_evt,
  input logic           fe_set,
  input logic           brk_evt,
  input logic           thr_write,
  input logic           thre_irq_en,
  input logic           tx_irq
);
  assert_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != '0) |-> status_word[7]);

  assert_sum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[7] && !status_rd) |=> status_word[7]);

  assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> status_word[1]);

  assert_frm_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !fe_set) |=> !status_word[3]);

  assert_brk_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> status_word[4]);

  assert_thre_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> !status_word[5]);

  assert_temt_needs_thre_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> !status_word[6]);

  assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[5] && thre_irq_en) |-> tx_irq);
endmodule

bind uart_line_status uls_checker #(.ECW($clog2(DEPTH + 1))) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_word (status_word),
  .status_rd   (status_rd),
  .err_count   (err_count),
  .overrun_evt (overrun_evt),
  .fe_set      (fe_set),
  .brk_evt     (brk_evt),
  .thr_write   (thr_write),
  .thre_irq_en (thre_irq_en),
  .tx_irq      (tx_irq)
);

// File: tb/uart_line_status_test.sv
module uart_line_status_test;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned OSR   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic rx_push = 1'b0, rx_pe = 1'b0, rx_fe = 1'b0, rx_bi = 1'b0, rx_pop = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic [7:0] rx_dout;
  logic serial_in = 1'b1, sample_tick = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_parity = 1'b0, cfg_two_stop = 1'b0;
  logic thr_write = 1'b0, tx_load = 1'b0, tx_shift_empty = 1'b1, thre_irq_en = 1'b0;
  logic [4:0] tx_level = 5'd0;
  logic tx_irq;

  int n_tests = 0;
  int n_fail = 0;
  int mdl_cnt = 0;
  logic [7:0] exp_q[$];
  event pop_ev;

  always #10 clk = ~clk;

  uart_line_status #(.DEPTH(DEPTH), .OSR(OSR)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_push(rx_push), .rx_char(rx_char), .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi),
    .rx_pop(rx_pop), .rx_dout(rx_dout), .serial_in(serial_in), .sample_tick(sample_tick),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .thr_write(thr_write), .tx_load(tx_load), .tx_level(tx_level),
    .tx_shift_empty(tx_shift_empty), .thre_irq_en(thre_irq_en), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // break threshold restated from the requirement
  function automatic int word_samples(input int len_code, input int par, input int two);
    return OSR * (1 + (5 + len_code) + par + (two + 1));
  endfunction

  task automatic read_at(input logic [7:0] addr, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic pe, input logic fe, input logic bi);
    @(negedge clk);
    rx_push = 1'b1; rx_char = d; rx_pe = pe; rx_fe = fe; rx_bi = bi;
    if (mdl_cnt < DEPTH) begin
      exp_q.push_back(d);
      mdl_cnt++;
    end
    @(negedge clk);
    rx_push = 1'b0; rx_pe = 1'b0; rx_fe = 1'b0; rx_bi = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rx_pop = 1'b1;
    -> pop_ev;
    @(negedge clk);
    rx_pop = 1'b0;
    if (mdl_cnt > 0) mdl_cnt--;
  endtask

  // scoreboard monitor: compares the head as each pop is issued
  initial begin
    forever begin
      @(pop_ev);
      #2;
      if (exp_q.size() == 0) chk("R2 pop with empty model", 32'h1, 32'h0);
      else chk("R2 pop order", {24'h0, rx_dout}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int thr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_at(8'h14, v); chk("R1 reset status", {24'h0, v}, 32'h60);
    chk("R1 reset irq", {31'h0, tx_irq}, 32'h0);

    // R2 data ready and ordering
    push(8'hA1, 0, 0, 0); push(8'hB2, 0, 0, 0); push(8'hC3, 0, 0, 0);
    read_at(8'h14, v); chk("R2 ready set", {24'h0, v}, 32'h61);
    pop(); pop(); pop();
    read_at(8'h14, v); chk("R2 ready clear", {24'h0, v}, 32'h60);

    // R3 overrun
    for (int i = 0; i < DEPTH + 1; i++) push(8'h10 + 8'(i), 0, 0, 0);
    read_at(8'h14, v); chk("R3 overrun set", {24'h0, v}, 32'h63);
    read_at(8'h14, v); chk("R3 overrun cleared", {24'h0, v}, 32'h61);
    for (int i = 0; i < DEPTH; i++) pop();
    read_at(8'h14, v); chk("R3 drained", {24'h0, v}, 32'h60);

    // R4 parity, wrong offset, R5 / R6 summary
    push(8'h55, 1, 0, 0);
    read_at(8'h10, v); chk("R4 other offset reads 0", {24'h0, v}, 32'h0);
    read_at(8'h14, v); chk("R4 parity set, untouched by other offset", {24'h0, v}, 32'hE5);
    read_at(8'h14, v); chk("R5 summary kept while queued", {24'h0, v}, 32'hE1);
    pop();
    read_at(8'h14, v); chk("R6 summary held after pop", {24'h0, v}, 32'hE0);
    read_at(8'h14, v); chk("R6 summary cleared by read", {24'h0, v}, 32'h60);

    // R4 framing
    push(8'h66, 0, 1, 0);
    read_at(8'h14, v); chk("R4 framing set", {24'h0, v}, 32'hE9);
    pop();
    read_at(8'h14, v); chk("R4 framing cleared", {24'h0, v}, 32'hE0);
    read_at(8'h14, v); chk("R6 clean", {24'h0, v}, 32'h60);

    // R5 break tag alone counts as errored
    push(8'h00, 0, 0, 1);
    read_at(8'h14, v); chk("R5 break tag summary", {24'h0, v}, 32'hE1);
    pop();
    read_at(8'h14, v); read_at(8'h14, v);
    chk("R5 break tag cleared", {24'h0, v}, 32'h60);

    // R7 / R8 break, shortest frame
    cfg_len = 2'd0; cfg_parity = 1'b0; cfg_two_stop = 1'b0;
    thr = word_samples(0, 0, 0);
    @(negedge clk); serial_in = 1'b0;
    repeat (thr - 1) @(negedge clk);
    read_at(8'h14, v); chk("R7 exactly W samples no break", {24'h0, v}, 32'h60);
    read_at(8'h14, v); chk("R8 break set wins over read", {24'h0, v}, 32'h70);
    read_at(8'h14, v); chk("R7 break cleared, no retrigger", {24'h0, v}, 32'h60);
    @(negedge clk); serial_in = 1'b1;
    repeat (2) @(negedge clk);

    // R7 longest frame
    cfg_len = 2'd3; cfg_parity = 1'b1; cfg_two_stop = 1'b1;
    thr = word_samples(3, 1, 1);
    @(negedge clk); serial_in = 1'b0;
    repeat (thr - 1) @(negedge clk);
    read_at(8'h14, v); chk("R7 long frame at W", {24'h0, v}, 32'h60);
    read_at(8'h14, v); chk("R7 long frame beyond W", {24'h0, v}, 32'h70);
    @(negedge clk); serial_in = 1'b1;
    read_at(8'h14, v);

    // R9 / R10 / R11 transmit side
    @(negedge clk); thre_irq_en = 1'b1;
    #1 chk("R11 irq with empty holding", {31'h0, tx_irq}, 32'h1);
    @(negedge clk); thr_write = 1'b1; tx_level = 5'd1;
    @(negedge clk); thr_write = 1'b0;
    #1 chk("R11 irq off after write", {31'h0, tx_irq}, 32'h0);
    read_at(8'h14, v); chk("R9 write clears holding empty", {24'h0, v}, 32'h00);
    @(negedge clk); tx_level = 5'd2;
    @(negedge clk); tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0; tx_level = 5'd1;
    read_at(8'h14, v); chk("R9 load above level 1 no set", {24'h0, v}, 32'h00);
    @(negedge clk); tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0; tx_level = 5'd0; tx_shift_empty = 1'b0;
    read_at(8'h14, v); chk("R10 shift busy", {24'h0, v}, 32'h20);
    chk("R11 irq after last load", {31'h0, tx_irq}, 32'h1);
    @(negedge clk); tx_shift_empty = 1'b1;
    read_at(8'h14, v); chk("R10 all empty", {24'h0, v}, 32'h60);
    @(negedge clk); thre_irq_en = 1'b0;
    #1 chk("R11 irq disabled", {31'h0, tx_irq}, 32'h0);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule